// File: doc/BRIEF.md
# Coalescing Host Interrupt Controller

This block gathers interrupt causes raised inside a device and presents them to a host processor on a single interrupt line. Causes come from two places: single-cycle event pulses from internal units (firmware, queue logic, RF-kill and temperature monitors, power management), and event pulses from the DMA flow handler. Flow-handler events are latched in their own status word and also folded into grouped bits of the main status word, so one read of the main status tells the host which family of causes fired.

The host sees a small 32-bit register port: a coalescing configuration word, the main status word (write 1 to clear), an enable mask and the flow-handler status word (write 1 to clear). To cut the interrupt rate, the line is held back for a programmable window, counted in units of 32 microsecond ticks, that restarts whenever the host acknowledges every pending cause. A high-priority receive event skips that window. A second byte of the configuration word turns on a periodic receive interrupt whose period is also counted in 32-tick units.

Top module: `coal_irq_ctl`

## Requirements
- R1: A status bit (main or flow-handler) is cleared only by a host write that has a 1 at that bit position; a written 0 leaves the bit as it was.
- R2: When a hardware event sets a bit in the same cycle that a host write clears it, the bit ends up set; other bits in that write are still cleared.
- R3: Flow-handler event bits 16, 17 and 30 set the same bits of the flow-handler status word and set main status bit 31.
- R4: Flow-handler event bit 31 sets flow-handler status bit 31 and main status bit 29; flow-handler event bits 0 and 1 set those flow-handler bits and main status bit 27. Flow-handler event bits outside {31,30,17,16,1,0} are ignored.
- R5: Event pulses on evtIn bits 26, 25, 7, 6, 1 and 0 set the main status bit of the same index; pulses on any other evtIn bit leave the status word unchanged.
- R6: Register offsets: 0x004 configuration (bits 7:0 window length, bits 15:8 periodic length, upper bits read 0), 0x008 main status, 0x00C mask (all 32 bits read back), 0x010 flow-handler status; other offsets read 0.
- R7: With the window expired, irqOut is high exactly when status AND mask is non-zero; a pending cause whose mask bit is 0 does not raise it.
- R8: A host write that leaves the main status word all zero restarts the window at (window length x 32) ticks; until it has run out, irqOut stays low for masked causes, and events arriving meanwhile do not lengthen it.
- R9: While flow-handler status bit 30 is pending and mask bit 31 is set, irqOut is high even inside the window.
- R10: A periodic length P > 0 sets main status bit 28 once every P x 32 ticks; P = 0 never sets it.
- R11: After reset every register reads 0, the window is expired and irqOut is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| usTick | input | 1 | One-cycle pulse per microsecond |
| evtIn | input | 32 | Internal cause pulses, one per main status bit |
| fhEvt | input | 32 | Flow-handler event pulses |
| irqOut | output | 1 | Host interrupt line |

## Verification
Two pairs of functions collide on the same edge: a hardware event and a host write-1-clear hitting the same status bit, and a high-priority flow-handler event arriving while the coalescing window is still counting. The first is provoked by driving an event pulse and a clearing write in one cycle and reading the status word back; the second by acknowledging all causes to restart the window and then pulsing the bypass event, judging irqOut in the very next cycle and again after the bypass bit is cleared. The window end is judged on exact cycles counted from the acknowledging write, with a second event injected mid-window.

// File: rtl/coal_irq_pkg.sv
package coal_irq_pkg;
  localparam int unsigned DATA_W = 32;

  // register byte offsets
  localparam int unsigned OFF_CFG  = 'h004;
  localparam int unsigned OFF_STAT = 'h008;
  localparam int unsigned OFF_MASK = 'h00C;
  localparam int unsigned OFF_FH   = 'h010;

  // main status bit positions
  localparam int unsigned B_RX       = 31;
  localparam int unsigned B_HWERR    = 29;
  localparam int unsigned B_PERIODIC = 28;
  localparam int unsigned B_TX       = 27;

  // flow-handler status bit positions
  localparam int unsigned F_ERR   = 31;
  localparam int unsigned F_HIPRI = 30;
  localparam int unsigned F_RX1   = 17;
  localparam int unsigned F_RX0   = 16;
  localparam int unsigned F_TX1   = 1;
  localparam int unsigned F_TX0   = 0;

  // causes taken straight from evtIn
  localparam logic [DATA_W-1:0] DIRECT_MASK = 32'h0600_00C3;
  // implemented flow-handler bits
  localparam logic [DATA_W-1:0] FH_IMPL = 32'hC003_0003;

  typedef struct packed {
    logic wrCfg;
    logic wrStat;
    logic wrMask;
    logic wrFh;
    logic perFire;
  } strobe_t;
endpackage

// File: rtl/coal_irq_ctrl.sv
module coal_irq_ctrl
  import coal_irq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned UNIT_TICKS = 32,
  parameter int unsigned CFG_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              usTick,
  input  logic [CFG_W-1:0]  winCfg,
  input  logic [CFG_W-1:0]  perCfg,
  input  logic              ackAll,
  output strobe_t           strb,
  output logic              winDone
);
  localparam int unsigned PRE_W  = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
  localparam int unsigned WCNT_W = CFG_W + PRE_W + 1;

  logic [PRE_W-1:0]  preQ;
  logic              unitPulse;
  logic [CFG_W-1:0]  perCntQ;
  logic              perHit;
  logic [WCNT_W-1:0] winQ;
  logic [WCNT_W-1:0] winLoad;

  // register decode
  always_comb begin
    strb.wrCfg   = regWe && (regAddr == ADDR_W'(OFF_CFG));
    strb.wrStat  = regWe && (regAddr == ADDR_W'(OFF_STAT));
    strb.wrMask  = regWe && (regAddr == ADDR_W'(OFF_MASK));
    strb.wrFh    = regWe && (regAddr == ADDR_W'(OFF_FH));
    strb.perFire = unitPulse && (perCfg != '0) && perHit;
  end

  // 32-tick unit prescaler for the periodic timer
  generate
    if (UNIT_TICKS > 1) begin : g_pre
      assign unitPulse = usTick && (preQ == PRE_W'(UNIT_TICKS - 1));
      always_ff @(posedge clk) begin
        if (rst)         preQ <= '0;
        else if (usTick) preQ <= unitPulse ? '0 : preQ + 1'b1;
      end
    end else begin : g_nopre
      assign unitPulse = usTick;
      always_ff @(posedge clk) preQ <= '0;
    end
  endgenerate

  assign perHit = ({1'b0, perCntQ} + 1'b1) >= {1'b0, perCfg};

  always_ff @(posedge clk) begin
    if (rst) perCntQ <= '0;
    else if (unitPulse) begin
      if (perCfg == '0 || perHit) perCntQ <= '0;
      else                        perCntQ <= perCntQ + 1'b1;
    end
  end

  // coalescing window, counted directly in ticks
  assign winLoad = WCNT_W'(winCfg) * WCNT_W'(UNIT_TICKS);

  always_ff @(posedge clk) begin
    if (rst)                        winQ <= '0;
    else if (ackAll)                winQ <= winLoad;
    else if (usTick && winQ != '0)  winQ <= winQ - 1'b1;
  end

  assign winDone = (winQ == '0);

  AST_WIN_RELOAD: assert property (@(posedge clk) disable iff (rst)
    ackAll |=> (winQ == WCNT_W'($past(winCfg)) * WCNT_W'(UNIT_TICKS))); // R8
  AST_WIN_NO_EXTEND: assert property (@(posedge clk) disable iff (rst)
    (!ackAll && winQ != '0) |=> (winQ <= $past(winQ))); // R8
  AST_PERIODIC_OFF: assert property (@(posedge clk) disable iff (rst)
    (perCfg == '0) |-> !strb.perFire); // R10
endmodule

// File: rtl/coal_irq_dp.sv
module coal_irq_dp
  import coal_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CFG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [DATA_W-1:0] evtIn,
  input  logic [DATA_W-1:0] fhEvt,
  input  logic              winDone,
  output logic [DATA_W-1:0] regRdata,
  output logic [CFG_W-1:0]  winCfg,
  output logic [CFG_W-1:0]  perCfg,
  output logic              ackAll,
  output logic              irqOut
);
  logic [DATA_W-1:0] statQ, maskQ, fhQ;
  logic [DATA_W-1:0] setMain, setFh, clrMain, clrFh, statNext, fhNext;
  logic              bypass;

  // cause folding
  always_comb begin
    setMain = evtIn & DIRECT_MASK;
    setMain[B_RX]       = fhEvt[F_RX0] | fhEvt[F_RX1] | fhEvt[F_HIPRI];
    setMain[B_HWERR]    = fhEvt[F_ERR];
    setMain[B_TX]       = fhEvt[F_TX0] | fhEvt[F_TX1];
    setMain[B_PERIODIC] = strb.perFire;
    setFh   = fhEvt & FH_IMPL;
    clrMain = strb.wrStat ? regWdata : '0;
    clrFh   = strb.wrFh   ? regWdata : '0;
    // hardware set outranks host clear
    statNext = (statQ & ~clrMain) | setMain;
    fhNext   = (fhQ & ~clrFh) | setFh;
  end

  assign ackAll = strb.wrStat && (statNext == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      statQ  <= '0;
      fhQ    <= '0;
      maskQ  <= '0;
      winCfg <= '0;
      perCfg <= '0;
    end else begin
      statQ <= statNext;
      fhQ   <= fhNext;
      if (strb.wrMask) maskQ <= regWdata;
      if (strb.wrCfg) begin
        winCfg <= regWdata[CFG_W-1:0];
        perCfg <= regWdata[CFG_W +: CFG_W];
      end
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_W'(OFF_CFG):  regRdata = DATA_W'({perCfg, winCfg});
      ADDR_W'(OFF_STAT): regRdata = statQ;
      ADDR_W'(OFF_MASK): regRdata = maskQ;
      ADDR_W'(OFF_FH):   regRdata = fhQ;
      default:           regRdata = '0;
    endcase
  end

  assign bypass = fhQ[F_HIPRI] & maskQ[B_RX];
  assign irqOut = ((|(statQ & maskQ)) && winDone) || bypass;

  AST_STAT_W1C_ONLY: assert property (@(posedge clk) disable iff (rst)
    !strb.wrStat |=> ((statQ & $past(statQ)) == $past(statQ))); // R1
  AST_FH_W1C_ONLY: assert property (@(posedge clk) disable iff (rst)
    !strb.wrFh |=> ((fhQ & $past(fhQ)) == $past(fhQ))); // R1
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|setMain) |=> ((statQ & $past(setMain)) == $past(setMain))); // R2
  AST_BYPASS_FIRES: assert property (@(posedge clk) disable iff (rst)
    (fhQ[F_HIPRI] && maskQ[B_RX]) |-> irqOut); // R9
endmodule

// File: rtl/coal_irq_ctl.sv
module coal_irq_ctl
  import coal_irq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned UNIT_TICKS = 32,
  parameter int unsigned CFG_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              usTick,
  input  logic [31:0]       evtIn,
  input  logic [31:0]       fhEvt,
  output logic              irqOut
);
  strobe_t          strb;
  logic             winDone;
  logic             ackAll;
  logic [CFG_W-1:0] winCfg;
  logic [CFG_W-1:0] perCfg;

  coal_irq_ctrl #(.ADDR_W(ADDR_W), .UNIT_TICKS(UNIT_TICKS), .CFG_W(CFG_W)) u_ctrl (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr), .usTick(usTick),
    .winCfg(winCfg), .perCfg(perCfg), .ackAll(ackAll),
    .strb(strb), .winDone(winDone)
  );

  coal_irq_dp #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .regAddr(regAddr), .regWdata(regWdata),
    .evtIn(evtIn), .fhEvt(fhEvt), .winDone(winDone), .regRdata(regRdata),
    .winCfg(winCfg), .perCfg(perCfg), .ackAll(ackAll), .irqOut(irqOut)
  );
endmodule

// File: tb/coal_irq_ctl_bench.sv
module coal_irq_ctl_bench;
  logic        clk = 0;
  logic        rst = 1;
  logic        regWe = 0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        usTick = 0;
  logic [31:0] evtIn = '0;
  logic [31:0] fhEvt = '0;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam logic [11:0] A_CFG = 12'h004, A_STAT = 12'h008, A_MASK = 12'h00C, A_FH = 12'h010;

  always #2 clk = ~clk;

  coal_irq_ctl u_coal_irq_ctl (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .usTick(usTick), .evtIn(evtIn), .fhEvt(fhEvt), .irqOut(irqOut)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    regWe = 1; regAddr = a; regWdata = d;
    step();
    regWe = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    regAddr = a; #1; v = regRdata;
  endtask

  task automatic clearAll();
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_FH, 32'hFFFF_FFFF);
  endtask

  function automatic logic [31:0] fhToMain(int i);
    if (i == 16 || i == 17 || i == 30) return 32'h8000_0000;
    if (i == 31) return 32'h2000_0000;
    if (i == 0 || i == 1) return 32'h0800_0000;
    return 32'h0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) step();
    rst = 0;
    step();

    // R11 reset state
    rd(A_CFG, v);  chk("R11 cfg", v, 0);
    rd(A_STAT, v); chk("R11 stat", v, 0);
    rd(A_MASK, v); chk("R11 mask", v, 0);
    rd(A_FH, v);   chk("R11 fh", v, 0);
    chk("R11 irq", {31'b0, irqOut}, 0);

    // R6 register map
    wr(A_MASK, 32'hA5A5_5A5A); rd(A_MASK, v); chk("R6 mask readback", v, 32'hA5A5_5A5A);
    wr(A_CFG, 32'hFFFF_1234);  rd(A_CFG, v);  chk("R6 cfg bytes", v, 32'h0000_1234);
    rd(12'h014, v); chk("R6 unmapped", v, 0);
    wr(A_CFG, 0); wr(A_MASK, 0);

    // R5 sweep of every direct cause bit
    for (int i = 0; i < 32; i++) begin
      evtIn = 32'h1 << i; step(); evtIn = 0;
      rd(A_STAT, v);
      chk("R5 direct cause", v, (32'h0600_00C3 >> i) & 1 ? (32'h1 << i) : 32'h0);
      wr(A_STAT, 32'h1 << i); rd(A_STAT, v); chk("R1 w1c clears", v, 0);
    end

    // R3 R4 sweep of every flow-handler bit
    for (int i = 0; i < 32; i++) begin
      fhEvt = 32'h1 << i; step(); fhEvt = 0;
      rd(A_FH, v);
      chk("R3/R4 fh latch", v, (32'hC003_0003 >> i) & 1 ? (32'h1 << i) : 32'h0);
      rd(A_STAT, v);
      chk(i == 16 || i == 17 || i == 30 ? "R3 fh rx fold" : "R4 fh fold", v, fhToMain(i));
      clearAll();
    end

    // R1 zero write keeps, R2 set wins over clear
    evtIn = 32'h0000_0041; step(); evtIn = 0;
    wr(A_STAT, 0); rd(A_STAT, v); chk("R1 zero write keeps", v, 32'h41);
    regWe = 1; regAddr = A_STAT; regWdata = 32'h41; evtIn = 32'h1;
    step(); regWe = 0; evtIn = 0;
    rd(A_STAT, v); chk("R2 set beats clear", v, 32'h1);
    clearAll();

    // R7 masking with expired window
    wr(A_MASK, 32'h8000_0003);
    evtIn = 32'h40; step(); evtIn = 0;
    chk("R7 masked cause quiet", {31'b0, irqOut}, 0);
    evtIn = 32'h1; step(); evtIn = 0;
    chk("R7 unmasked cause fires", {31'b0, irqOut}, 1);
    clearAll();

    // R8 coalescing window of 3 units = 96 ticks
    usTick = 1;
    wr(A_CFG, 32'h0000_0003);
    evtIn = 32'h1; step(); evtIn = 0;
    chk("R8 window idle before ack", {31'b0, irqOut}, 1);
    wr(A_STAT, 32'hFFFF_FFFF);          // edge E: window loads 96
    evtIn = 32'h1; step(); evtIn = 0;   // E+1
    repeat (48) step();                 // E+49
    evtIn = 32'h2; step(); evtIn = 0;   // E+50
    chk("R8 held mid window", {31'b0, irqOut}, 0);
    repeat (45) step();                 // E+95
    chk("R8 held last cycle", {31'b0, irqOut}, 0);
    step();                             // E+96
    chk("R8 released on time", {31'b0, irqOut}, 1);

    // R9 bypass inside a fresh window
    wr(A_STAT, 32'hFFFF_FFFF);
    fhEvt = 32'h4000_0000; step(); fhEvt = 0;
    chk("R9 bypass immediate", {31'b0, irqOut}, 1);
    wr(A_FH, 32'h4000_0000);
    chk("R9 bypass cleared, window holds", {31'b0, irqOut}, 0);
    wr(A_CFG, 0);
    clearAll();

    // R10 periodic every 2 units from a clean reset
    usTick = 0; rst = 1; step(); step(); rst = 0; step();
    wr(A_CFG, 32'h0000_0200);
    usTick = 1;
    repeat (63) step();
    rd(A_STAT, v); chk("R10 periodic not yet", v, 0);
    step();
    rd(A_STAT, v); chk("R10 periodic fires", v, 32'h1000_0000);
    wr(A_CFG, 0);
    wr(A_STAT, 32'hFFFF_FFFF);
    repeat (200) step();
    rd(A_STAT, v); chk("R10 periodic off", v, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule